// File: doc/BRIEF.md
# Three-wire serial EEPROM target (64 x 16)

This block is a synthesizable model of a word-organised serial EEPROM that sits behind a three-wire
select/clock/data link. The memory holds 64 words of 16 bits. A host raises the select line, clocks
an instruction in on the data input (a start bit of 1, a two-bit operation code and a six-bit word
address), and then either clocks write data in or clocks read data out on the data output pin. The
output has its own enable, so the pin can be tri-stated at the chip level.

Everything runs on a fast system clock. The select, serial clock, data and program-enable inputs are
synchronised. Each rising edge of the serial clock is detected as a single-cycle event. A write-enable
latch gates every programming operation, and so does a program-enable pin. Programming is self-timed:
once the host lowers select at a legal point, a counter that runs for a parameterised number of system
clocks stands in for the programming interval. During that interval the array is updated one word per
clock. While select is high, the data pin reports whether the part is busy or ready.

The serial clock must stay at each level for at least four system clocks.

Top module: `mw_eeprom_target`

## Requirements
- R1: An instruction begins at the first serial-clock rise that samples a 1 while select is high. Zeros before it are ignored. Eight more bits follow, most significant first: a two-bit opcode, then a six-bit address.
- R2: Opcode 10 is a read. After the last address bit, the output drives one 0 bit. On each following serial-clock rise it then presents the next bit of the 16-bit word, most significant first.
- R3: A read that keeps being clocked moves to the next address after every 16 data bits, and goes from address 63 back to 0.
- R4: Opcode 01 is a single-word write. It takes the 16 data bits that follow. The word is stored only when select falls after exactly 16 data bits.
- R5: Opcode 11 is a page write. It accepts words one after another. After each word only address bits [1:0] advance (11 goes to 00) and bits [5:2] stay fixed. A fifth and a sixth word therefore replace the first and second.
- R6: Opcode 00 with address bits [5:4] = 01 is write-all. It stores its 16-bit word at all 64 addresses.
- R7: A write-enable latch is cleared by reset. Opcode 00 with address bits [5:4] = 11 sets it, and [5:4] = 00 clears it. While it is clear, every write form is dropped. Reads work whatever its state.
- R8: When the program-enable input is low at the moment select falls, no programming starts. Left unconnected, the input reads as high.
- R9: An instruction is discarded and nothing is stored if select falls in the header, in the middle of a data word, or after more bits than a single write or write-all takes.
- R10: After programming starts, and while select is high, the output drives 0 during the programming interval and 1 after it. This status stays until a start bit is clocked in. While select is low the output enable is 0.
- R11: The programming interval lasts PROG_CYCLES system clocks (at least 65). An instruction whose start bit arrives during the interval is ignored entirely.
- R12: Out of reset the output enable is 0 and the write-enable latch is clear. Array contents are not touched by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Select, active high |
| sk_i | input | 1 | Serial clock; data sampled on its rising edge |
| di_i | input | 1 | Serial data in |
| pe_i | input | 1 | Program enable; low blocks programming |
| do_o | output | 1 | Serial data out / busy-ready status |
| do_oe_o | output | 1 | Output enable for do_o (0 means high impedance) |

## Verification
Single-word writes at random addresses are followed by reads. These separate correct address decode and bit order from shifted or reversed data. Page writes of one to six words start at random offsets inside a page. They show whether only the low two address bits wrap, and whether later words overwrite earlier ones. Long reads that cross the top of the array, and a read of all 64 words after a write-all, show the increment and wrap. Truncated, overlong and busy-time instructions, as well as writes with the latch or the program-enable pin low, must leave the array unchanged. The status sequence is sampled just before and just after the end of the programming interval.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start bit
    ST_HDR,    // shifting opcode and address
    ST_RD,     // streaming read data
    ST_WDATA,  // shifting a data word
    ST_WFULL,  // a data word just completed
    ST_SKIP    // instruction finished or discarded, wait for select low
  } mw_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_PAGE  = 2'b11;

  localparam logic [1:0] SUB_LOCK  = 2'b00;
  localparam logic [1:0] SUB_FILL  = 2'b01;
  localparam logic [1:0] SUB_OPEN  = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic pe_i,
  output logic cs_s,
  output logic di_s,
  output logic pe_s,
  output logic sk_rise,
  output logic cs_fall
);
  logic [STAGES-1:0] cs_p, sk_p, di_p, pe_p;
  logic sk_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
      pe_p <= '0;
      sk_d <= 1'b0;
      cs_d <= 1'b0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs_i};
      sk_p <= {sk_p[STAGES-2:0], sk_i};
      di_p <= {di_p[STAGES-2:0], di_i};
      pe_p <= {pe_p[STAGES-2:0], pe_i};
      sk_d <= sk_p[STAGES-1];
      cs_d <= cs_p[STAGES-1];
    end
  end

  assign cs_s    = cs_p[STAGES-1];
  assign di_s    = di_p[STAGES-1];
  assign pe_s    = pe_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-1] & ~sk_d;
  assign cs_fall = cs_d & ~cs_p[STAGES-1];
endmodule

// File: rtl/mw_word_ram.sv
module mw_word_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mw_prog_engine.sv
module mw_prog_engine #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int SW          = 2,
  parameter int PROG_CYCLES = 250000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             buf_clr,
  input  logic             buf_wr,
  input  logic [SW-1:0]    buf_slot,
  input  logic [DW-1:0]    buf_data,
  input  logic             start,
  input  logic             all_mode,
  input  logic [AW-SW-1:0] base_hi,
  output logic             busy,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [DW-1:0]    wdata
);
  localparam int DEPTH    = 1 << AW;
  localparam int NSLOT    = 1 << SW;
  localparam int PROG_LEN = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH + 1;
  localparam int TW       = $clog2(PROG_LEN);

  logic [DW-1:0]    slot_q [NSLOT];
  logic [NSLOT-1:0] vld_q;
  logic             all_q;
  logic [AW-SW-1:0] hi_q;
  logic [TW-1:0]    tcnt;
  logic [AW:0]      idx;

  // staging words: no reset, small distributed storage
  always_ff @(posedge clk) begin
    if (buf_wr) slot_q[buf_slot] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      tcnt  <= '0;
      idx   <= '0;
      vld_q <= '0;
      all_q <= 1'b0;
      hi_q  <= '0;
    end else begin
      if (buf_clr)     vld_q <= '0;
      else if (buf_wr) vld_q[buf_slot] <= 1'b1;

      if (start && !busy) begin
        busy  <= 1'b1;
        tcnt  <= '0;
        idx   <= '0;
        all_q <= all_mode;
        hi_q  <= base_hi;
      end else if (busy) begin
        if (!idx[AW]) idx <= idx + 1'b1;
        if (tcnt == TW'(PROG_LEN - 1)) busy <= 1'b0;
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // one array word per clock during the interval
  always_comb begin
    we    = 1'b0;
    waddr = idx[AW-1:0];
    wdata = slot_q[0];
    if (busy) begin
      if (all_q) begin
        we = !idx[AW];
      end else if (idx < (AW+1)'(NSLOT)) begin
        we    = vld_q[idx[SW-1:0]];
        waddr = {hi_q, idx[SW-1:0]};
        wdata = slot_q[idx[SW-1:0]];
      end
    end
  end

  assert_busy_from_start_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_interval_length_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tcnt) == TW'(PROG_LEN - 1));
endmodule

// File: rtl/mw_eeprom_target.sv
module mw_eeprom_target #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int PAGE_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic pe_i,
  output logic do_o,
  output logic do_oe_o
);
  import mw_pkg::*;

  localparam int HW      = AW + 2;
  localparam int CNT_MAX = (DW > HW) ? DW : HW;
  localparam int CW      = $clog2(CNT_MAX);
  localparam int RBW     = $clog2(DW);
  localparam logic [RBW-1:0] RB_TOP = RBW'(DW - 1);

  logic cs_s, di_s, pe_s, sk_rise, cs_fall;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i), .pe_i(pe_i),
    .cs_s(cs_s), .di_s(di_s), .pe_s(pe_s), .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mw_state_e            st;
  logic [CW-1:0]        cnt;
  logic [HW-2:0]        hdr;
  logic [DW-2:0]        sh;
  logic [PAGE_W-1:0]    slot;
  logic [AW-PAGE_W-1:0] hi;
  logic                 all_q, page_q, wen_q, stat_on, rd_drv, do_bit;
  logic [AW-1:0]        rd_addr;
  logic [RBW-1:0]       rd_bit;
  logic                 buf_clr, buf_wr, eng_start, eng_busy;
  logic [PAGE_W-1:0]    buf_slot;
  logic [DW-1:0]        buf_data;
  logic                 ram_we;
  logic [AW-1:0]        ram_waddr;
  logic [DW-1:0]        ram_wdata, rdata;
  logic [HW-1:0]        hdr_full;
  logic [DW-1:0]        word_full;
  logic [1:0]           op;
  logic [AW-1:0]        adr;

  assign hdr_full  = {hdr, di_s};
  assign word_full = {sh, di_s};
  assign op        = hdr_full[HW-1 -: 2];
  assign adr       = hdr_full[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      hdr       <= '0;
      sh        <= '0;
      slot      <= '0;
      hi        <= '0;
      all_q     <= 1'b0;
      page_q    <= 1'b0;
      wen_q     <= 1'b0;
      stat_on   <= 1'b0;
      rd_drv    <= 1'b0;
      do_bit    <= 1'b0;
      rd_addr   <= '0;
      rd_bit    <= '0;
      buf_clr   <= 1'b0;
      buf_wr    <= 1'b0;
      buf_slot  <= '0;
      buf_data  <= '0;
      eng_start <= 1'b0;
    end else begin
      buf_clr   <= 1'b0;
      buf_wr    <= 1'b0;
      eng_start <= 1'b0;
      if (cs_fall) begin
        // programming only from a clean word boundary
        if (st == ST_WFULL && !eng_busy && wen_q && pe_s) begin
          eng_start <= 1'b1;
          stat_on   <= 1'b1;
        end
        st     <= ST_IDLE;
        rd_drv <= 1'b0;
        cnt    <= '0;
      end else if (sk_rise && cs_s) begin
        unique case (st)
          ST_IDLE: begin
            if (di_s) begin
              stat_on <= 1'b0;
              cnt     <= '0;
              st      <= eng_busy ? ST_SKIP : ST_HDR;
            end
          end
          ST_HDR: begin
            hdr <= hdr_full[HW-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HW - 1)) begin
              cnt <= '0;
              if (op == OPC_READ) begin
                st      <= ST_RD;
                rd_addr <= adr;
                rd_bit  <= '0;
                rd_drv  <= 1'b1;
                do_bit  <= 1'b0;
              end else if (op == OPC_WRITE || op == OPC_PAGE) begin
                st      <= ST_WDATA;
                all_q   <= 1'b0;
                page_q  <= (op == OPC_PAGE);
                slot    <= adr[PAGE_W-1:0];
                hi      <= adr[AW-1:PAGE_W];
                buf_clr <= 1'b1;
              end else begin
                st <= ST_SKIP;
                unique case (adr[AW-1 -: 2])
                  SUB_OPEN: wen_q <= 1'b1;
                  SUB_LOCK: wen_q <= 1'b0;
                  SUB_FILL: begin
                    st      <= ST_WDATA;
                    all_q   <= 1'b1;
                    page_q  <= 1'b0;
                    slot    <= '0;
                    hi      <= '0;
                    buf_clr <= 1'b1;
                  end
                  default: ;
                endcase
              end
            end
          end
          ST_RD: begin
            do_bit <= rdata[RB_TOP - rd_bit];
            rd_bit <= rd_bit + 1'b1;
            if (rd_bit == RB_TOP) begin
              rd_bit  <= '0;
              rd_addr <= rd_addr + 1'b1;
            end
          end
          ST_WDATA: begin
            sh  <= word_full[DW-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) begin
              buf_wr   <= 1'b1;
              buf_slot <= slot;
              buf_data <= word_full;
              if (page_q) slot <= slot + 1'b1;
              cnt      <= '0;
              st       <= ST_WFULL;
            end
          end
          ST_WFULL: begin
            if (page_q) begin
              sh  <= word_full[DW-2:0];
              cnt <= CW'(1);
              st  <= ST_WDATA;
            end else begin
              st <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  mw_prog_engine #(.AW(AW), .DW(DW), .SW(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_engine (
    .clk(clk), .rst(rst),
    .buf_clr(buf_clr), .buf_wr(buf_wr), .buf_slot(buf_slot), .buf_data(buf_data),
    .start(eng_start), .all_mode(all_q), .base_hi(hi),
    .busy(eng_busy), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
  );

  mw_word_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rd_addr), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      do_o    <= 1'b0;
      do_oe_o <= 1'b0;
    end else begin
      do_oe_o <= cs_s && (rd_drv || stat_on);
      do_o    <= rd_drv ? do_bit : !eng_busy;
    end
  end

  assert_leading_zero_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && sk_rise && cs_s && !di_s && !cs_fall) |=> st == ST_IDLE);
  assert_dummy_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_drv) |-> !do_bit);
  assert_latch_guard_R7: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(wen_q));
  assert_pe_guard_R8: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(pe_s));
  assert_discard_partial_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && st != ST_WFULL) |=> !eng_start);
  assert_hiz_deselected_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> !do_oe_o);
  assert_busy_reports_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (cs_s && stat_on && eng_busy && !rd_drv) |=> (do_oe_o && !do_o));
endmodule

// File: tb/tb_mw_eeprom_target.sv
module tb_mw_eeprom_target;
  localparam int PROG = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic pe_drive = 1'b0, pe_val = 1'b1;
  wire  pe = pe_drive ? pe_val : 1'b1;  // undriven pin pulled high
  logic do_o, do_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic so, soe;
  logic [15:0] model [64];
  bit wen_m = 1'b0;
  logic [15:0] pw [8];

  always #10 clk = ~clk;

  mw_eeprom_target #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .cs_i(cs), .sk_i(sk), .di_i(di), .pe_i(pe),
    .do_o(do_o), .do_oe_o(do_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    di = b; tick(4); sk = 1'b1; tick(4); sk = 1'b0; tick(4);
    o = do_o; oe = do_oe;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bit_io(v[i], so, soe);
  endtask

  task automatic begin_cmd;
    cs = 1'b1; tick(4);
  endtask

  task automatic end_cmd;
    cs = 1'b0; di = 1'b0; tick(6);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    begin_cmd; send_bits({23'd0, 3'b101, a}, 9); send_bits({16'd0, d}, 16); end_cmd;
    if (wen_m && pe) model[a] = d;
    tick(PROG + 20);
  endtask

  task automatic do_page(input logic [5:0] a, input int n);
    logic [1:0] s;
    s = a[1:0];
    begin_cmd; send_bits({23'd0, 3'b111, a}, 9);
    for (int i = 0; i < n; i++) send_bits({16'd0, pw[i]}, 16);
    end_cmd;
    if (wen_m && pe)
      for (int i = 0; i < n; i++) begin model[{a[5:2], s}] = pw[i]; s = s + 2'd1; end
    tick(PROG + 20);
  endtask

  task automatic do_ext(input logic [1:0] code);
    begin_cmd; send_bits({23'd0, 3'b100, code, 4'b0000}, 9); end_cmd;
    if (code == 2'b11) wen_m = 1'b1;
    if (code == 2'b00) wen_m = 1'b0;
  endtask

  task automatic do_fill(input logic [15:0] d);
    begin_cmd; send_bits({23'd0, 9'b100010000}, 9); send_bits({16'd0, d}, 16); end_cmd;
    if (wen_m && pe) for (int i = 0; i < 64; i++) model[i] = d;
    tick(PROG + 20);
  endtask

  task automatic do_read(input logic [5:0] a, input int n, input string tag);
    logic [15:0] w;
    begin_cmd; send_bits({23'd0, 3'b110, a}, 9);
    chk({tag, " R2 dummy oe"}, 32'(soe), 32'd1);
    chk({tag, " R2 dummy bit"}, 32'(so), 32'd0);
    for (int k = 0; k < n; k++) begin
      for (int b = 15; b >= 0; b--) begin bit_io(1'b0, so, soe); w[b] = so; end
      chk(tag, 32'(w), 32'(model[a + 6'(k)]));
    end
    end_cmd;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd7311));
    tick(5); rst = 1'b0; tick(3);

    // R12: output released out of reset
    cs = 1'b1; tick(10);
    chk("R12 oe after reset", 32'(do_oe), 32'd0);
    cs = 1'b0; tick(6);

    // R1: leading zeros before the start bit, then enable
    begin_cmd; send_bits(32'b000, 3); send_bits({23'd0, 9'b100110000}, 9); end_cmd;
    wen_m = 1'b1;

    // R6: write-all then full sequential read with wrap
    do_fill(16'h5A3C);
    do_read(6'd0, 64, "R6 fill readback");

    // R4: single-word writes
    do_write(6'd5, 16'hBEEF);
    do_write(6'd63, 16'h1234);
    do_write(6'd0, 16'h8001);
    do_read(6'd5, 1, "R4 write");
    // R3: wrap from 63 to 0
    do_read(6'd62, 3, "R3 wrap");

    // R5: six words from offset 2 of page 1
    for (int i = 0; i < 6; i++) pw[i] = 16'hA000 + 16'(i);
    do_page(6'd6, 6);
    do_read(6'd3, 6, "R5 page wrap");

    // R7: latch cleared blocks writes; reads still work
    do_ext(2'b00);
    do_write(6'd5, 16'h0F0F);
    do_fill(16'hFFFF);
    do_read(6'd4, 2, "R7 locked");
    do_ext(2'b11);

    // R8: program-enable low blocks, released pin allows
    pe_drive = 1'b1; pe_val = 1'b0;
    do_write(6'd10, 16'hCAFE);
    do_read(6'd10, 1, "R8 pe low");
    pe_drive = 1'b0;
    do_write(6'd10, 16'hCAFE);
    do_read(6'd10, 1, "R8 pe released");

    // R9: truncated and overlong instructions are dropped
    begin_cmd; send_bits({23'd0, 3'b101, 6'd20}, 9); send_bits(32'h3FF, 10); end_cmd; tick(PROG + 20);
    begin_cmd; send_bits({23'd0, 3'b101, 6'd21}, 9); send_bits(32'h1FFFF, 17); end_cmd; tick(PROG + 20);
    begin_cmd; send_bits({23'd0, 3'b111, 6'd22}, 9); send_bits(32'hFFFFF, 20); end_cmd; tick(PROG + 20);
    begin_cmd; send_bits({23'd0, 3'b101}, 3); end_cmd; tick(PROG + 20);
    do_read(6'd20, 3, "R9 discard");

    // R10 / R11: status sequence on the pin
    begin_cmd; send_bits({23'd0, 3'b101, 6'd9}, 9); send_bits(32'hA5C3, 16);
    cs = 1'b0; di = 1'b0; tick(2);
    chk("R10 hi-z with select low", 32'(do_oe), 32'd0);
    tick(4);
    model[9] = 16'hA5C3;
    cs = 1'b1; tick(10);
    chk("R10 busy oe", 32'(do_oe), 32'd1);
    chk("R10 busy level", 32'(do_o), 32'd0);
    tick(PROG - 30);
    chk("R11 still busy near end", 32'(do_o), 32'd0);
    tick(40);
    chk("R10 ready level", 32'(do_o), 32'd1);
    chk("R10 ready oe", 32'(do_oe), 32'd1);
    bit_io(1'b1, so, soe);
    chk("R10 start bit ends status", 32'(soe), 32'd0);
    send_bits({24'd0, 2'b10, 6'd9}, 8);
    chk("R2 dummy after status", 32'(so), 32'd0);
    for (int b = 15; b >= 0; b--) begin bit_io(1'b0, so, soe); w[b] = so; end
    chk("R10 written word", 32'(w), 32'h0000A5C3);
    end_cmd;
    chk("R10 hi-z after read", 32'(do_oe), 32'd0);

    // R11: write arriving during the interval is ignored
    begin_cmd; send_bits({23'd0, 3'b101, 6'd30}, 9); send_bits(32'h1111, 16); end_cmd;
    model[30] = 16'h1111;
    begin_cmd; send_bits({23'd0, 3'b101, 6'd31}, 9); send_bits(32'h2222, 16); end_cmd;
    tick(PROG + 20);
    do_read(6'd30, 2, "R11 busy ignore");

    // R12: reset clears the latch, keeps the array
    rst = 1'b1; tick(3); rst = 1'b0; tick(3);
    wen_m = 1'b0;
    do_write(6'd5, 16'h7777);
    do_read(6'd5, 1, "R12 latch cleared");
    do_ext(2'b11);

    // random mix against the model
    for (int it = 0; it < 30; it++) begin
      int unsigned r;
      logic [5:0] ra;
      int n;
      r  = $urandom % 5;
      ra = 6'($urandom);
      case (r)
        0, 1: do_write(ra, 16'($urandom));
        2: begin
          n = 1 + int'($urandom % 6);
          for (int i = 0; i < n; i++) pw[i] = 16'($urandom);
          do_page(ra, n);
        end
        3: do_read(ra, 1 + int'($urandom % 3), "R3 random read");
        default: do_ext(($urandom % 4 == 0) ? 2'b00 : 2'b11);
      endcase
    end
    do_read(6'd0, 64, "R4 final sweep");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule